// File: doc/BRIEF.md
# Register-Register Shift Execution Unit

This block executes the three register-register shift operations of a 64-bit RISC-V integer core that can also run in 32-bit mode. It takes the instruction word, both source operand values and a mode flag, and produces the shifted result in the same cycle. The decode of the shift instructions is part of the block. A valid flag tells the surrounding execute stage whether the word was one of the three shifts.

There is one 64-bit logarithmic shifter for both modes. In 64-bit mode the shift amount comes from the six low bits of the second operand. In 32-bit mode only five bits count, the top stage of the shifter never fires, and the upper half of the first operand is ignored. The 32-bit result is then sign-extended to 64 bits. Left shifts reuse the right shifter by reversing the bits before and after it.

Top module: `reg_shift_unit`

## Requirements
- R1: A word with bits [6:0] = 0110011 decodes as a shift when bits [14:12] = 001 and bits [31:25] = 0000000 (left logical), when bits [14:12] = 101 and bits [31:25] = 0000000 (right logical), or when bits [14:12] = 101 and bits [31:25] = 0100000 (right arithmetic); valid_o is then high. So 0x001111b3, 0x001151b3 and 0x401151b3 are the left, logical right and arithmetic right shifts. The register index fields (bits [11:7], [19:15], [24:20]) have no effect.
- R2: Any other instruction word drives valid_o low and result_o to zero.
- R3: In 64-bit mode (rv64_i = 1) the shift amount is rs2_i[5:0]. Bits [63:6] of rs2_i have no effect.
- R4: In 32-bit mode (rv64_i = 0) the shift amount is rs2_i[4:0]. An amount of 32 gives the operand unchanged, and 33, 37 and 63 act as shifts by 1, 5 and 31.
- R5: In 32-bit mode the shift uses only rs1_i[31:0], and result_o[63:32] copies result_o[31].
- R6: The left shift fills the vacated low bits with zeros. Bits moved past the top bit (bit 31 in 32-bit mode, bit 63 in 64-bit mode) are lost. A one moved into bit 31 in 32-bit mode gives a negative result.
- R7: The logical right shift fills the vacated upper bits with zeros.
- R8: The arithmetic right shift fills the vacated upper bits with the operand's sign bit: bit 31 in 32-bit mode, bit 63 in 64-bit mode. Shifting all ones right by 1 gives all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs1_i | input | 64 | Value to be shifted |
| rs2_i | input | 64 | Value that holds the shift amount |
| rv64_i | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| result_o | output | 64 | Shift result, zero when the word is not a shift |
| valid_o | output | 1 | High when the word decodes as one of the three shifts |

## Verification
The hardest case to reach is the 32-bit logical right shift by zero of an operand whose bit 31 is set. It is the only logical right shift whose result comes out negative, and it is also where a fault in the stage that is forced off would show. The sweep reaches it by passing every value 0 to 63 in the amount field, with random upper bits, for operands with bit 31 both set and clear. Amounts 32 and 64-bit-only amounts then also hit the masking corners. A separate group of near-miss encodings, each with one field off, checks the decoder.

// File: rtl/reg_shift_pkg.sv
package reg_shift_pkg;
  typedef enum logic [1:0] {
    SH_NONE   = 2'd0,
    SH_LEFT   = 2'd1,
    SH_RLOG   = 2'd2,
    SH_RARITH = 2'd3
  } shift_op_e;

  localparam logic [31:0] DEC_MASK   = 32'hFE00_707F;
  localparam logic [31:0] PAT_LEFT   = 32'h0000_1033;
  localparam logic [31:0] PAT_RLOG   = 32'h0000_5033;
  localparam logic [31:0] PAT_RARITH = 32'h4000_5033;
endpackage

// File: rtl/reg_shift_decode.sv
module reg_shift_decode
  import reg_shift_pkg::*;
(
  input  logic [31:0] instr_i,
  output shift_op_e   op_o
);
  logic [31:0] key;
  assign key = instr_i & DEC_MASK;

  always_comb begin
    unique case (key)
      PAT_LEFT:   op_o = SH_LEFT;
      PAT_RLOG:   op_o = SH_RLOG;
      PAT_RARITH: op_o = SH_RARITH;
      default:    op_o = SH_NONE;
    endcase
  end

  always_comb begin
    if (op_o != SH_NONE)
      AST_DEC_OPCODE: assert (instr_i[6:0] == 7'b0110011); // R1
  end
endmodule

// File: rtl/reg_shift_barrel.sv
// Right shifter with log2(W) stages; stage k moves by 2**k.
module reg_shift_barrel #(
  parameter int W  = 64,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  data_i,
  input  logic [SW-1:0] amt_i,
  input  logic          fill_i,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] stage [SW+1];
  assign stage[0] = data_i;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{D{fill_i}}, stage[k][W-1:D]} : stage[k];
  end

  assign data_o = stage[SW];

  always_comb begin
    if (amt_i == '0)
      AST_ZERO_AMT_PASS: assert (data_o == data_i); // R3
    if (amt_i != '0)
      AST_TOP_FILL: assert (data_o[W-1] == fill_i); // R7
  end
endmodule

// File: rtl/reg_shift_unit.sv
module reg_shift_unit
  import reg_shift_pkg::*;
#(
  parameter int XLEN = 64,
  localparam int HALF = XLEN / 2,
  localparam int SW   = $clog2(XLEN)
) (
  input  logic [31:0]     instr_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic            rv64_i,
  output logic [XLEN-1:0] result_o,
  output logic            valid_o
);
  shift_op_e       op;
  logic            left;
  logic [SW-1:0]   amt;
  logic [XLEN-1:0] src, src_rev, pre, post, post_rev, aligned, res;
  logic            fill;

  reg_shift_decode u_dec (
    .instr_i (instr_i),
    .op_o    (op)
  );

  assign valid_o = (op != SH_NONE);
  assign left    = (op == SH_LEFT);

  // modulo by a power of two: plain masking, top stage off in 32-bit mode
  assign amt = rv64_i ? SW'(rs2_i % XLEN) : SW'(rs2_i % HALF);

  always_comb begin
    if (rv64_i)               src = rs1_i;
    else if (op == SH_RARITH) src = {{HALF{rs1_i[HALF-1]}}, rs1_i[HALF-1:0]};
    else                      src = {{HALF{1'b0}}, rs1_i[HALF-1:0]};
  end

  assign fill = (op == SH_RARITH) & (rv64_i ? rs1_i[XLEN-1] : rs1_i[HALF-1]);

  for (genvar i = 0; i < XLEN; i++) begin : g_rev
    assign src_rev[i]  = src[XLEN-1-i];
    assign post_rev[i] = post[XLEN-1-i];
  end

  assign pre = left ? src_rev : src;

  reg_shift_barrel #(.W(XLEN)) u_bar (
    .data_i (pre),
    .amt_i  (amt),
    .fill_i (fill),
    .data_o (post)
  );

  assign aligned  = left ? post_rev : post;
  assign res      = rv64_i ? aligned : {{HALF{aligned[HALF-1]}}, aligned[HALF-1:0]};
  assign result_o = valid_o ? res : '0;

  always_comb begin
    if (!valid_o)
      AST_INVALID_ZERO: assert (result_o == '0); // R2
    if (valid_o && !rv64_i)
      AST_RV32_SEXT: assert (result_o[XLEN-1:HALF] == {HALF{result_o[HALF-1]}}); // R5
    if (op == SH_LEFT && amt != '0)
      AST_LEFT_ZERO_FILL: assert (result_o[0] == 1'b0); // R6
    if (op == SH_RLOG && rv64_i && amt != '0)
      AST_RLOG_TOP_CLEAR: assert (result_o[XLEN-1] == 1'b0); // R7
    if (op == SH_RARITH)
      AST_RARITH_SIGN: assert ((rv64_i ? result_o[XLEN-1] : result_o[HALF-1])
                               == (rv64_i ? rs1_i[XLEN-1] : rs1_i[HALF-1])); // R8
  end
endmodule

// File: tb/reg_shift_unit_test.sv
module reg_shift_unit_test;
  logic        clk = 1'b0;
  logic [31:0] instr;
  logic [63:0] rs1, rs2, result;
  logic        rv64, valid;
  int checks = 0;
  int errors = 0;

  localparam logic [31:0] W_SLL = 32'h001111b3;
  localparam logic [31:0] W_SRL = 32'h001151b3;
  localparam logic [31:0] W_SRA = 32'h401151b3;

  always #5 clk = ~clk;

  reg_shift_unit uut (
    .instr_i  (instr),
    .rs1_i    (rs1),
    .rs2_i    (rs2),
    .rv64_i   (rv64),
    .result_o (result),
    .valid_o  (valid)
  );

  function automatic logic [63:0] model(input int kind, input logic m64,
                                        input logic [63:0] a, input logic [63:0] b);
    logic [31:0] r32;
    int sh;
    if (m64) begin
      sh = int'(b[5:0]);
      case (kind)
        0: return a << sh;
        1: return a >> sh;
        default: return $unsigned($signed(a) >>> sh);
      endcase
    end
    sh = int'(b[4:0]);
    case (kind)
      0: r32 = a[31:0] << sh;
      1: r32 = a[31:0] >> sh;
      default: r32 = $unsigned($signed(a[31:0]) >>> sh);
    endcase
    return {{32{r32[31]}}, r32};
  endfunction

  task automatic check(input string req, input logic [63:0] exp_r, input logic exp_v);
    @(negedge clk);
    checks++;
    if (result !== exp_r || valid !== exp_v) begin
      errors++;
      $display("FAIL %s instr=%h rv64=%0b rs1=%h rs2=%h: got %h/%0b exp %h/%0b",
               req, instr, rv64, rs1, rs2, result, valid, exp_r, exp_v);
    end
  endtask

  task automatic run(input string req, input int kind, input logic m64,
                     input logic [63:0] a, input logic [63:0] b);
    logic [31:0] w;
    w = (kind == 0) ? W_SLL : (kind == 1) ? W_SRL : W_SRA;
    instr = w; rv64 = m64; rs1 = a; rs2 = b;
    check(req, model(kind, m64, a, b), 1'b1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] pats [6];
    instr = '0; rs1 = '0; rs2 = '0; rv64 = 1'b0;
    // idle inputs: all-zero word is no shift (R2)
    check("R2", 64'h0, 1'b0);

    // named corners, 32-bit mode
    run("R4", 0, 1'b0, 64'h0000_0000_1234_5678, 64'd32);
    run("R4", 0, 1'b0, 64'h0000_0000_0000_0001, 64'd33);
    run("R4", 1, 1'b0, 64'h0000_0000_8000_0000, 64'd63);
    run("R4", 2, 1'b0, 64'h0000_0000_8000_0000, 64'd37);
    run("R8", 2, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    run("R6", 0, 1'b0, 64'h0000_0000_0000_0001, 64'd31);
    run("R6", 0, 1'b0, 64'h0000_0000_F000_0001, 64'd4);
    run("R7", 1, 1'b0, 64'h0000_0000_8000_0000, 64'd1);
    run("R5", 1, 1'b0, 64'hABCD_EF01_8000_0000, 64'd0);
    run("R5", 2, 1'b0, 64'h7FFF_FFFF_0000_0000, 64'd3);
    // named corners, 64-bit mode
    run("R3", 0, 1'b1, 64'h0000_0000_0000_0001, 64'hFFFF_FFFF_FFFF_FFC0);
    run("R3", 1, 1'b1, 64'h8000_0000_0000_0000, 64'd63);
    run("R8", 2, 1'b1, 64'h8000_0000_0000_0000, 64'd63);
    run("R6", 0, 1'b1, 64'h8000_0000_0000_0001, 64'd1);

    // sweep: every amount field value, random upper amount bits, several operands
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 3; k++) begin
        for (int s = 0; s < 64; s++) begin
          pats[0] = 64'hFFFF_FFFF_FFFF_FFFF;
          pats[1] = 64'h8000_0000_8000_0000;
          pats[2] = 64'h0000_0001_0000_0001;
          pats[3] = 64'h5A5A_A5A5_7E81_0FF0;
          pats[4] = {$urandom, $urandom};
          pats[5] = {$urandom, $urandom};
          for (int p = 0; p < 6; p++) begin
            logic [63:0] b;
            b = {$urandom, $urandom};
            b[5:0] = 6'(s);
            if (m == 1) run(k == 0 ? "R6_R3" : k == 1 ? "R7_R3" : "R8_R3", k, 1'b1, pats[p], b);
            else        run(k == 0 ? "R6_R4" : k == 1 ? "R7_R4" : "R8_R4", k, 1'b0, pats[p], b);
          end
        end
      end
    end

    // R1: register index fields do not matter
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w;
      w = W_SRA | ({$urandom} & 32'h01FF_8F80);
      instr = w; rv64 = 1'b1; rs1 = 64'hF000_0000_0000_0000; rs2 = 64'd4;
      check("R1", 64'hFF00_0000_0000_0000, 1'b1);
    end
    instr = W_SLL; check("R1", 64'h0000_0000_0000_0000, 1'b1);
    instr = W_SRL; check("R1", 64'h0F00_0000_0000_0000, 1'b1);

    // R2: near-miss encodings
    begin
      logic [31:0] bad [7];
      bad[0] = 32'h401111b3; // left with arithmetic funct7
      bad[1] = 32'h001111b7; // wrong opcode
      bad[2] = 32'h000001b3; // add
      bad[3] = 32'h021151b3; // funct7 0000001
      bad[4] = 32'h00111193; // immediate-form opcode
      bad[5] = 32'h601151b3; // funct7 0110000
      bad[6] = 32'h001171b3; // funct3 111
      for (int i = 0; i < 7; i++) begin
        instr = bad[i]; rv64 = i[0]; rs1 = 64'hFFFF_FFFF_FFFF_FFFF; rs2 = 64'd3;
        check("R2", 64'h0, 1'b0);
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule